// File: doc/BRIEF.md
# Single-Precision Float and Signed Integer Converter

The block converts between a 32-bit single-precision floating value and a signed integer of 8, 16 or 32 bits. It works in both directions. Each operation is issued with a one-cycle `start` pulse and finishes in a fixed number of cycles. The operation carries its direction, its destination or source width, and, for float-to-integer work, a choice between truncation and rounding. The result comes back together with negative, zero, overflow and carry flags. A fault flag is raised when the float source holds the reserved encoding.

The float layout is sign in bit 31, an 8-bit exponent in bits 30:23 biased by 127, and a 23-bit fraction in bits 22:0 with a hidden leading one. When the exponent field is zero and the sign is clear, the value is zero whatever the fraction holds. When the exponent field is zero and the sign is set, the encoding is reserved.

Control is a three-state machine:
- `ST_IDLE` waits for work. IDLE→EXEC is taken on `start`, and the operands are latched on that edge.
- `ST_EXEC` registers the converted value and the flags. EXEC→DONE is taken unconditionally.
- `ST_DONE` raises `done` for one cycle. DONE→IDLE is taken unconditionally.

Top module: `sfp_int_convert`

## Requirements
- R1: A `start` sampled high in `ST_IDLE` is accepted. `done` is high for exactly one cycle, two clock edges after the accepting edge. A `start` seen in `ST_EXEC` or `ST_DONE` is ignored. `result` and the flags keep their values until the next accepted operation has executed. After reset, `done`, `result`, the flags and `fault` are all zero.
- R2: A float source whose exponent field is zero and whose sign is clear converts as the value zero, whatever its fraction bits hold.
- R3: A float source with sign 1 and exponent field 0, converted to an integer, sets `fault`. In that case `result` is zero and N, Z and V are all clear.
- R4: With `round_en` low, float-to-integer conversion truncates toward zero. `size` encodes the width as 00 byte, 01 word, 10 longword; 11 is also treated as a longword. The destination value is sign-extended into all 32 bits of `result`.
- R5: With `round_en` high and a longword destination, float-to-integer conversion rounds to the nearest integer, and halves go away from zero. For byte and word destinations `round_en` has no effect.
- R6: V is set when the float-to-integer value lies outside the signed range of the destination. The destination then holds the low-order bits of the true integer, sign-extended into `result`.
- R7: Integer-to-float from a byte or a word is exact. The source is the low 8 or 16 bits of `src`, read as signed; the higher bits are ignored.
- R8: Longword-to-float keeps 24 significant bits. It adds one at the first discarded bit and renormalises once if that carry overflows the significand.
- R9: Integer-to-float of zero gives the all-zero encoding, with Z set.
- R10: N shows that the destination value is negative and Z that it is zero. C is always 0. V and `fault` are always 0 for integer-to-float.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Issue an operation (taken only when idle) |
| to_float | input | 1 | 1: integer to float, 0: float to integer |
| round_en | input | 1 | Round instead of truncate (longword destination only) |
| size | input | 2 | Integer width: 00 byte, 01 word, 10/11 longword |
| src | input | 32 | Source operand |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Converted value |
| flag_n | output | 1 | Destination negative |
| flag_z | output | 1 | Destination zero |
| flag_v | output | 1 | Integer overflow |
| flag_c | output | 1 | Carry, always 0 |
| fault | output | 1 | Reserved-operand fault |

## Verification
Each result is registered by the edge that follows the accepting edge, and `done` rises at that same edge. Result, flags and `done` are therefore due two edges after `start` is sampled, and `done` falls one edge later. The bench drives every input on the falling edge. It looks at `done` on the falling edge after the accepting edge, where it expects zero, and reads the result and flags on the next falling edge, where `done` must be high. A further falling edge confirms that `done` has dropped and that the held values are still unchanged.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
    localparam int WORD_W = 32;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int BIAS   = 127;
    localparam int MAG_W  = FRAC_W + 1;
    localparam int SIZE_W = 2;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_LALT = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_EXEC = 2'b01,
        ST_DONE = 2'b10
    } state_e;

    function automatic int dest_bits(size_e sz);
        unique case (sz)
            SZ_BYTE: return 8;
            SZ_WORD: return 16;
            default: return WORD_W;
        endcase
    endfunction
endpackage

// File: rtl/sfp_to_int.sv
module sfp_to_int
    import fcvt_pkg::*;
(
    input  logic [WORD_W-1:0] fbits,
    input  size_e             size,
    input  logic              round_en,
    output logic [WORD_W-1:0] ival,
    output logic              neg,
    output logic              zero,
    output logic              ovf,
    output logic              rsv
);
    localparam int QW     = MAG_W + WORD_W + 8;
    localparam int K_WRAP = FRAC_W + WORD_W - 1;

    logic              sgn;
    logic [EXP_W-1:0]  ex;
    int                ke;
    int                dw;
    logic [QW-1:0]     wide, q, mag_i, full, lim;
    logic [WORD_W-1:0] low;
    logic              huge;

    always_comb begin
        sgn  = fbits[WORD_W-1];
        ex   = fbits[WORD_W-2:FRAC_W];
        ke   = int'(ex) - BIAS;
        wide = QW'({1'b1, fbits[FRAC_W-1:0]});
        q    = '0;
        huge = 1'b0;
        if (ex == '0 || ke < -1)
            q = '0;
        else if (ke <= FRAC_W - 1)
            q = wide >> (FRAC_W - 1 - ke);
        else if (ke <= K_WRAP)
            q = wide << (ke - FRAC_W + 1);
        else
            huge = 1'b1;

        // q holds |x| with one fraction bit; rounding adds that half bit
        mag_i = (q >> 1) + ((round_en && size[1]) ? QW'(q[0]) : '0);
        full  = sgn ? (~mag_i + QW'(1)) : mag_i;
        low   = WORD_W'(full);
        dw    = dest_bits(size);
        lim   = (QW'(1) << (dw - 1)) - QW'(1) + QW'(sgn);

        for (int i = 0; i < WORD_W; i++)
            ival[i] = (i < dw) ? low[i] : low[dw-1];
        ovf = huge || (mag_i > lim);
        rsv = sgn && (ex == '0);
        if (rsv) begin
            ival = '0;
            ovf  = 1'b0;
        end
        neg  = ival[WORD_W-1];
        zero = !rsv && (ival == '0);
    end
endmodule

// File: rtl/int_to_sfp.sv
module int_to_sfp
    import fcvt_pkg::*;
(
    input  logic [WORD_W-1:0] src,
    input  size_e             size,
    output logic [WORD_W-1:0] fbits,
    output logic              neg,
    output logic              zero
);
    localparam int DROP = WORD_W - MAG_W - 1;

    int                dw;
    int                lead;
    logic [WORD_W-1:0] sx, mag, norm;
    logic [MAG_W:0]    m, sum;
    logic              carry;
    logic [FRAC_W-1:0] frac_o;
    logic [EXP_W-1:0]  exp_o;

    always_comb begin
        dw = dest_bits(size);
        for (int i = 0; i < WORD_W; i++)
            sx[i] = (i < dw) ? src[i] : src[dw-1];
        mag  = sx[WORD_W-1] ? (~sx + WORD_W'(1)) : sx;
        lead = 0;
        for (int i = 0; i < WORD_W; i++)
            if (mag[i]) lead = i;
        norm  = mag << (WORD_W - 1 - lead);
        m     = (MAG_W+1)'(norm >> DROP);
        // m[MAG_W:1] is the significand, m[0] the first dropped bit
        sum   = {1'b0, m[MAG_W:1]} + (MAG_W+1)'(m[0]);
        carry = sum[MAG_W];
        frac_o = carry ? sum[MAG_W-1:1] : sum[FRAC_W-1:0];
        exp_o  = EXP_W'(BIAS + lead + int'(carry));
        fbits  = (mag == '0) ? '0 : {sx[WORD_W-1], exp_o, frac_o};
        neg    = fbits[WORD_W-1];
        zero   = (fbits == '0);
    end
endmodule

// File: rtl/sfp_int_convert.sv
module sfp_int_convert
    import fcvt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              to_float,
    input  logic              round_en,
    input  logic [SIZE_W-1:0] size,
    input  logic [WORD_W-1:0] src,
    output logic              done,
    output logic [WORD_W-1:0] result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c,
    output logic              fault
);
    state_e            state_q, state_d;
    logic              to_float_q, round_q;
    logic [SIZE_W-1:0] size_q;
    logic [WORD_W-1:0] src_q;

    logic [WORD_W-1:0] f2i_val, i2f_val;
    logic              f2i_n, f2i_z, f2i_v, f2i_rsv, i2f_n, i2f_z;

    sfp_to_int u_f2i (
        .fbits(src_q), .size(size_e'(size_q)), .round_en(round_q),
        .ival(f2i_val), .neg(f2i_n), .zero(f2i_z), .ovf(f2i_v), .rsv(f2i_rsv)
    );

    int_to_sfp u_i2f (
        .src(src_q), .size(size_e'(size_q)),
        .fbits(i2f_val), .neg(i2f_n), .zero(i2f_z)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            to_float_q <= 1'b0;
            round_q    <= 1'b0;
            size_q     <= '0;
            src_q      <= '0;
        end else if (state_q == ST_IDLE && start) begin
            to_float_q <= to_float;
            round_q    <= round_en;
            size_q     <= size;
            src_q      <= src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            flag_v <= 1'b0;
            fault  <= 1'b0;
        end else if (state_q == ST_EXEC) begin
            if (to_float_q) begin
                result <= i2f_val;
                flag_n <= i2f_n;
                flag_z <= i2f_z;
                flag_v <= 1'b0;
                fault  <= 1'b0;
            end else begin
                result <= f2i_val;
                flag_n <= f2i_n;
                flag_z <= f2i_z;
                flag_v <= f2i_v;
                fault  <= f2i_rsv;
            end
        end
    end

    assign done   = (state_q == ST_DONE);
    assign flag_c = 1'b0;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1
    AST_START_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> ##1 done); // R1
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_EXEC) |=> $stable(result)); // R1
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (result == '0 && !flag_n && !flag_z && !flag_v)); // R3
    AST_FLOAT_NO_V: assert property (@(posedge clk) disable iff (!rst_n)
        (done && to_float_q) |-> (!flag_v && !fault)); // R10
    AST_N_IS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (flag_n == result[WORD_W-1])); // R10
    AST_Z_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (flag_z == (result == '0))); // R10
endmodule

// File: tb/sfp_int_convert_tb_top.sv
module sfp_int_convert_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        to_float = 1'b0;
    logic        round_en = 1'b0;
    logic [1:0]  size = 2'b00;
    logic [31:0] src = '0;
    logic        done, flag_n, flag_z, flag_v, flag_c, fault;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sfp_int_convert dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .to_float(to_float),
        .round_en(round_en), .size(size), .src(src), .done(done),
        .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
        .flag_c(flag_c), .fault(fault)
    );

    // {req[7:0], to_float, round_en, size[1:0], src[31:0], expected[31:0], {N,Z,V,fault}}
    localparam int NV = 37;
    localparam logic [79:0] VEC [NV] = '{
        {8'd4, 1'b0, 1'b0, 2'd2, 32'h3F800000, 32'h00000001, 4'b0000}, // R4 1.0
        {8'd4, 1'b0, 1'b0, 2'd2, 32'h40300000, 32'h00000002, 4'b0000}, // R4 2.75
        {8'd4, 1'b0, 1'b0, 2'd0, 32'hC0300000, 32'hFFFFFFFE, 4'b1000}, // R4 -2.75 byte
        {8'd4, 1'b0, 1'b0, 2'd1, 32'h46FFFE00, 32'h00007FFF, 4'b0000}, // R4 32767 word
        {8'd4, 1'b0, 1'b0, 2'd2, 32'h3F000000, 32'h00000000, 4'b0100}, // R4 0.5 trunc
        {8'd5, 1'b0, 1'b1, 2'd2, 32'h40200000, 32'h00000003, 4'b0000}, // R5 2.5
        {8'd5, 1'b0, 1'b1, 2'd2, 32'hC0200000, 32'hFFFFFFFD, 4'b1000}, // R5 -2.5
        {8'd5, 1'b0, 1'b1, 2'd2, 32'h40100000, 32'h00000002, 4'b0000}, // R5 2.25
        {8'd5, 1'b0, 1'b1, 2'd2, 32'hBF000000, 32'hFFFFFFFF, 4'b1000}, // R5 -0.5
        {8'd5, 1'b0, 1'b1, 2'd0, 32'h40200000, 32'h00000002, 4'b0000}, // R5 byte ignores rounding
        {8'd5, 1'b0, 1'b1, 2'd3, 32'h3F000000, 32'h00000001, 4'b0000}, // R5 size 11 as longword
        {8'd6, 1'b0, 1'b0, 2'd0, 32'h43960000, 32'h0000002C, 4'b0010}, // R6 300 to byte
        {8'd6, 1'b0, 1'b0, 2'd0, 32'h43800000, 32'h00000000, 4'b0110}, // R6 256 to byte
        {8'd6, 1'b0, 1'b0, 2'd1, 32'h47000000, 32'hFFFF8000, 4'b1010}, // R6 32768 word
        {8'd6, 1'b0, 1'b0, 2'd1, 32'hC7000000, 32'hFFFF8000, 4'b1000}, // R6 -32768 word
        {8'd6, 1'b0, 1'b0, 2'd2, 32'h4F000000, 32'h80000000, 4'b1010}, // R6 2^31
        {8'd6, 1'b0, 1'b0, 2'd2, 32'hCF000000, 32'h80000000, 4'b1000}, // R6 -2^31
        {8'd6, 1'b0, 1'b0, 2'd2, 32'h53800000, 32'h00000000, 4'b0110}, // R6 2^40
        {8'd6, 1'b0, 1'b0, 2'd2, 32'h7F000000, 32'h00000000, 4'b0110}, // R6 huge
        {8'd6, 1'b0, 1'b0, 2'd0, 32'h42FE0000, 32'h0000007F, 4'b0000}, // R6 127 byte
        {8'd6, 1'b0, 1'b0, 2'd0, 32'hC3000000, 32'hFFFFFF80, 4'b1000}, // R6 -128 byte
        {8'd6, 1'b0, 1'b0, 2'd0, 32'h43000000, 32'hFFFFFF80, 4'b1010}, // R6 128 byte
        {8'd2, 1'b0, 1'b0, 2'd2, 32'h007FFFFF, 32'h00000000, 4'b0100}, // R2 zero with fraction
        {8'd3, 1'b0, 1'b0, 2'd2, 32'h80000000, 32'h00000000, 4'b0001}, // R3 reserved
        {8'd3, 1'b0, 1'b1, 2'd0, 32'h80123456, 32'h00000000, 4'b0001}, // R3 reserved byte
        {8'd7, 1'b1, 1'b0, 2'd0, 32'h000000FF, 32'hBF800000, 4'b1000}, // R7 byte -1
        {8'd7, 1'b1, 1'b0, 2'd0, 32'hFFFFFF7F, 32'h42FE0000, 4'b0000}, // R7 byte 127
        {8'd7, 1'b1, 1'b0, 2'd1, 32'h00008000, 32'hC7000000, 4'b1000}, // R7 word -32768
        {8'd7, 1'b1, 1'b0, 2'd1, 32'h12347FFF, 32'h46FFFE00, 4'b0000}, // R7 word 32767
        {8'd9, 1'b1, 1'b0, 2'd2, 32'h00000000, 32'h00000000, 4'b0100}, // R9 long zero
        {8'd9, 1'b1, 1'b0, 2'd0, 32'h12345600, 32'h00000000, 4'b0100}, // R9 byte zero
        {8'd8, 1'b1, 1'b0, 2'd2, 32'h01000001, 32'h4B800001, 4'b0000}, // R8 half up
        {8'd8, 1'b1, 1'b0, 2'd2, 32'h01000003, 32'h4B800002, 4'b0000}, // R8 carry
        {8'd8, 1'b1, 1'b0, 2'd2, 32'h01000002, 32'h4B800001, 4'b0000}, // R8 exact
        {8'd8, 1'b1, 1'b0, 2'd2, 32'h7FFFFFFF, 32'h4F000000, 4'b0000}, // R8 renormalise
        {8'd8, 1'b1, 1'b0, 2'd2, 32'h80000000, 32'hCF000000, 4'b1000}, // R8 -2^31
        {8'd8, 1'b1, 1'b0, 2'd2, 32'hFFFFFFFF, 32'hBF800000, 4'b1000}  // R8 -1 long
    };

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 done in reset", {31'd0, done}, 32'd0);
        check(result == '0, "R1 result in reset", result, 32'd0);
        check({flag_n, flag_z, flag_v, flag_c, fault} == 5'd0, "R1 flags in reset",
              {27'd0, flag_n, flag_z, flag_v, flag_c, fault}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R1 done after reset", {31'd0, done}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [79:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vector %0d", v[79:72], i);
            to_float = v[71];
            round_en = v[70];
            size     = v[69:68];
            src      = v[67:36];
            start    = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(done == 1'b0, {tag, " R1 done early"}, {31'd0, done}, 32'd0);
            @(negedge clk);
            check(done == 1'b1, {tag, " R1 done due"}, {31'd0, done}, 32'd1);
            check(result == v[35:4], {tag, " result"}, result, v[35:4]);
            check({flag_n, flag_z, flag_v, fault} == v[3:0], {tag, " flags NZVF"},
                  {28'd0, flag_n, flag_z, flag_v, fault}, {28'd0, v[3:0]});
            check(flag_c == 1'b0, {tag, " R10 carry"}, {31'd0, flag_c}, 32'd0);
            @(negedge clk);
            check(done == 1'b0, {tag, " R1 done falls"}, {31'd0, done}, 32'd0);
        end

        // R1 start while busy is ignored; result holds
        to_float = 1'b0; round_en = 1'b0; size = 2'd2; src = 32'h40300000;
        start = 1'b1;
        @(negedge clk);
        src = 32'h43960000;
        @(negedge clk);
        check(done == 1'b1, "R1 busy done", {31'd0, done}, 32'd1);
        check(result == 32'd2, "R1 busy first result", result, 32'd2);
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R1 busy no repeat", {31'd0, done}, 32'd0);
        check(result == 32'd2, "R1 result held", result, 32'd2);
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 no second op", {31'd0, done}, 32'd0);
        check(result == 32'd2, "R1 result still held", result, 32'd2);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule